// File: doc/BRIEF.md
# GPIO Port Interrupt Trigger Detector

This block holds the interrupt logic for one GPIO port of eight pins. It takes pin values that have already been synchronised to its clock. For each pin, software picks one trigger condition: rising edge, falling edge, either edge, high level or low level. A detected condition sets a status bit for that pin. A port interrupt line is raised when any pin has its status bit set and is also enabled.

Software reaches the logic through a simple register port. A write channel carries a 12-bit offset and a 32-bit data word. A combinational read channel returns status, enable or trigger configuration. Status can be cleared by writing ones. Enable and trigger registers each have a masked-write alias, so one pin can be updated without a read-modify-write.

Edge and level triggers differ in how they treat a clear. An edge event is latched until software clears it. A level condition is re-evaluated on every cycle, so clearing it while the level is still active has no lasting effect.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, the status (offset 0x040), enable (0x050) and trigger (0x060) registers read zero and `irq_o` is low. Reads at any other offset return zero.
- R2: The trigger register holds three 8-bit lanes per port. Pin n uses bit n as polarity, bit n+8 as edge mode and bit n+16 as both-edges. Lanes (16,8,0) = 0,1,1 selects rising edge: a 0-to-1 change between consecutive cycles sets the status bit, and the bit stays set until cleared.
- R3: Lanes 0,1,0 select falling edge: a 1-to-0 change sets the status bit, and the bit stays set until cleared.
- R4: Lanes 1,1,0 select both edges: any change of the pin sets the status bit, and the bit stays set until cleared.
- R5: Lanes 0,0,1 select high level: one cycle after the pin is sampled, the status bit equals the pin value.
- R6: Lanes 0,0,0 select low level: one cycle after the pin is sampled, the status bit equals the inverse of the pin value.
- R7: Writing to offset 0x070 clears the edge-mode status bits that have a 1 in data bits [7:0]. Bits written as 0 are unchanged. If an edge and a clear arrive for the same pin in the same cycle, the status bit stays set. In level mode a clear has no lasting effect.
- R8: `irq_o` is registered. It equals the OR over all pins of (status AND enable) as it stood one cycle earlier.
- R9: A write to 0x050 loads the enable bits from data [7:0]. A write to 0x850 updates only the pins whose data bit 8+n is 1, setting each to data bit n.
- R10: A write to 0x060 loads all 24 trigger bits. A write to 0x860 updates only the polarity lane (bits [7:0]): pin n takes data bit n where data bit 8+n is 1, and the edge and both-edges lanes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Synchronised pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write offset |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 12 | Register read offset |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Port interrupt request |

## Verification
Each of the five trigger modes is swept across all pins with pseudo-random pin patterns and clear patterns. A mixed-mode run then gives each pin a different trigger. A design that swaps the falling and rising codes, or ignores the both-edges lane, fails on the first pattern where the modes diverge.

A directed case puts an edge and a clear on the same pin in the same cycle. A design that lets the clear win loses that event. Bits written as zero in a clear word must be left alone; a design that treats the clear as a plain overwrite wipes them.

Masked writes are checked against pins outside the mask. A design that ignores the mask half corrupts pins that should keep their value. A masked trigger write must not touch the edge or both-edges lanes.

The interrupt output is compared one cycle after status. A combinational output, or one that ignores enable, shows up immediately.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_STA = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_ENB = 12'h050;
  localparam logic [ADDR_W-1:0] OFS_TRG = 12'h060;
  localparam logic [ADDR_W-1:0] OFS_CLR = 12'h070;
  localparam logic [ADDR_W-1:0] OFS_MSK = 12'h800;

  typedef struct packed {
    logic both;
    logic edge_md;
    logic pol;
  } trig_t;
endpackage

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [NPIN-1:0]     en_o,
  output logic [3*NPIN-1:0]   trig_o,
  output logic [NPIN-1:0]     clr_o
);
  localparam int unsigned TW = 3 * NPIN;

  logic wr_enb, wr_enb_m, wr_trg, wr_trg_m;
  logic [NPIN-1:0] msk, val;

  assign wr_enb   = wr_en_i && (wr_addr_i == OFS_ENB);
  assign wr_enb_m = wr_en_i && (wr_addr_i == (OFS_ENB | OFS_MSK));
  assign wr_trg   = wr_en_i && (wr_addr_i == OFS_TRG);
  assign wr_trg_m = wr_en_i && (wr_addr_i == (OFS_TRG | OFS_MSK));
  assign msk      = wr_data_i[2*NPIN-1:NPIN];
  assign val      = wr_data_i[NPIN-1:0];
  assign clr_o    = (wr_en_i && (wr_addr_i == OFS_CLR)) ? val : '0;

  logic [TW-1:0] trig_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[i] <= 1'b0;
      end else if (wr_enb) begin
        en_o[i] <= val[i];
      end else if (wr_enb_m && msk[i]) begin
        en_o[i] <= val[i];
      end
    end

    // masked alias reaches the polarity lane only
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        trig_q[i] <= 1'b0;
      end else if (wr_trg) begin
        trig_q[i] <= val[i];
      end else if (wr_trg_m && msk[i]) begin
        trig_q[i] <= val[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q[TW-1:NPIN] <= '0;
    end else if (wr_trg) begin
      trig_q[TW-1:NPIN] <= wr_data_i[TW-1:NPIN];
    end
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/gpio_irq_pin.sv
`timescale 1ns/1ps
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_i,
  input  trig_t mode_i,
  input  logic  clr_i,
  output logic  sta_o
);
  logic pin_q, rise, fall, hit, sta_d;

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;
  assign hit  = mode_i.both ? (rise | fall) : (mode_i.pol ? rise : fall);

  always_comb begin
    if (mode_i.edge_md) sta_d = hit | (sta_o & ~clr_i);  // edge wins over clear
    else                sta_d = ~(pin_i ^ mode_i.pol);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      sta_o <= 1'b0;
    end else begin
      pin_q <= pin_i;
      sta_o <= sta_d;
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned TW = 3 * NPIN;

  logic [NPIN-1:0] en_q, sta_q, clr_pulse;
  logic [TW-1:0]   trig_q;

  gpio_irq_regs #(.NPIN(NPIN)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .en_o      (en_q),
    .trig_o    (trig_q),
    .clr_o     (clr_pulse)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    trig_t mode;
    assign mode.pol     = trig_q[i];
    assign mode.edge_md = trig_q[NPIN+i];
    assign mode.both    = trig_q[2*NPIN+i];

    gpio_irq_pin u_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[i]),
      .mode_i (mode),
      .clr_i  (clr_pulse[i]),
      .sta_o  (sta_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(sta_q & en_q);
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      OFS_STA: rd_data_o[NPIN-1:0] = sta_q;
      OFS_ENB: rd_data_o[NPIN-1:0] = en_q;
      OFS_TRG: rd_data_o[TW-1:0]   = trig_q;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk #(
  parameter int unsigned NPIN = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NPIN-1:0]   pin_i,
  input logic              irq_o,
  input logic [NPIN-1:0]   sta,
  input logic [NPIN-1:0]   en,
  input logic [3*NPIN-1:0] trig,
  input logic [NPIN-1:0]   clr
);
  // R2 R3 R4 R7: edge status set and not cleared stays set
  assert_edge_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sta & trig[2*NPIN-1:NPIN] & ~clr)) & ~sta) == '0);

  // R5 R6: level status tracks the sampled pin against polarity
  assert_level_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sta ^ ~($past(pin_i) ^ $past(trig[NPIN-1:0])))
              & ~$past(trig[2*NPIN-1:NPIN])) == '0);

  // R8: registered OR of enabled status
  assert_irq_reg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(sta & en)));

  // R8: no enables, no interrupt next cycle
  assert_irq_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |=> !irq_o);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pin_i  (pin_i),
  .irq_o  (irq_o),
  .sta    (sta_q),
  .en     (en_q),
  .trig   (trig_q),
  .clr    (clr_pulse)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pin = '0;
  logic        we = 1'b0;
  logic [11:0] wa = '0;
  logic [31:0] wd = '0;
  logic [11:0] ra = 12'h040;
  logic [31:0] rd;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  m_sta = '0, m_en = '0, m_prev = '0;
  logic [23:0] m_trig = '0;
  logic        m_irq = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  gpio_irq_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    ra = a;
    #0.5;
    chk(tag, rd, exp);
    ra = 12'h040;
    #0.1;
  endtask

  // one clock from a negedge: drive, advance model, return at next negedge
  task automatic cyc(input logic w, input logic [11:0] a, input logic [31:0] d, input logic [7:0] p);
    logic [7:0] clr, nsta;
    pin = p; we = w; wa = a; wd = d;
    @(posedge clk);
    clr = (w && a == 12'h070) ? d[7:0] : 8'h00;
    for (int i = 0; i < 8; i++) begin
      logic e, b, pl, r, f, h;
      pl = m_trig[i]; e = m_trig[8+i]; b = m_trig[16+i];
      r = p[i] & ~m_prev[i]; f = ~p[i] & m_prev[i];
      h = b ? (r | f) : (pl ? r : f);
      nsta[i] = e ? (h | (m_sta[i] & ~clr[i])) : (pl ? p[i] : ~p[i]);
    end
    m_irq = |(m_sta & m_en);
    m_sta = nsta;
    m_prev = p;
    if (w) begin
      if (a == 12'h050) m_en = d[7:0];
      if (a == 12'h850) m_en = (m_en & ~d[15:8]) | (d[7:0] & d[15:8]);
      if (a == 12'h060) m_trig = d[23:0];
      if (a == 12'h860) m_trig[7:0] = (m_trig[7:0] & ~d[15:8]) | (d[7:0] & d[15:8]);
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cmp(input string tag);
    rd_chk(tag, 12'h040, {24'h0, m_sta});
    chk("R8 irq", {31'h0, irq}, {31'h0, m_irq});
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0]  codes [5];
    string       tags  [5];
    logic [23:0] t;
    codes[0] = 3'b011; tags[0] = "R2 rising";
    codes[1] = 3'b010; tags[1] = "R3 falling";
    codes[2] = 3'b110; tags[2] = "R4 both";
    codes[3] = 3'b001; tags[3] = "R5 high";
    codes[4] = 3'b000; tags[4] = "R6 low";

    // R1 reset state
    #7;
    rd_chk("R1 status", 12'h040, 32'h0);
    rd_chk("R1 enable", 12'h050, 32'h0);
    rd_chk("R1 trigger", 12'h060, 32'h0);
    rd_chk("R1 other", 12'h070, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // uniform-mode sweeps
    for (int m = 0; m < 5; m++) begin
      t = {{8{codes[m][2]}}, {8{codes[m][1]}}, {8{codes[m][0]}}};
      cyc(1'b1, 12'h060, {8'h0, t}, pin);
      cyc(1'b1, 12'h050, 32'h000000A5 ^ m, pin);
      cyc(1'b1, 12'h070, 32'hFF, pin);
      cmp(tags[m]);
      for (int s = 0; s < 48; s++) begin
        step_lfsr();
        if (s % 4 == 3) cyc(1'b1, 12'h070, {24'h0, lfsr[15:8]}, lfsr[7:0]);
        else            cyc(1'b0, 12'h000, 32'h0, lfsr[7:0]);
        cmp(tags[m]);
      end
    end

    // mixed modes per pin, R7 clears interleaved
    t = '0;
    for (int i = 0; i < 8; i++) begin
      t[i]    = codes[i % 5][0];
      t[8+i]  = codes[i % 5][1];
      t[16+i] = codes[i % 5][2];
    end
    cyc(1'b1, 12'h060, {8'h0, t}, pin);
    cyc(1'b1, 12'h050, 32'hFF, pin);
    for (int s = 0; s < 80; s++) begin
      step_lfsr();
      if (s % 3 == 0) cyc(1'b1, 12'h070, {24'h0, lfsr[15:8]}, lfsr[7:0]);
      else            cyc(1'b0, 12'h000, 32'h0, lfsr[7:0]);
      cmp("R7 mixed");
    end

    // R7 directed: edge and clear in same cycle, zero bits untouched
    cyc(1'b1, 12'h060, 32'h000FF_FF, 8'h00);
    cyc(1'b1, 12'h070, 32'hFF, 8'h00);
    rd_chk("R7 cleared", 12'h040, 32'h0);
    cyc(1'b0, 12'h000, 32'h0, 8'h01);
    rd_chk("R2 set", 12'h040, 32'h01);
    cyc(1'b1, 12'h070, 32'h03, 8'h03);
    rd_chk("R7 edge wins", 12'h040, 32'h02);
    cyc(1'b1, 12'h070, 32'h00, 8'h03);
    rd_chk("R7 zero no effect", 12'h040, 32'h02);
    cmp("R7");

    // R5 level: clear has no lasting effect
    cyc(1'b1, 12'h060, 32'h0000FF, 8'h0F);
    cyc(1'b1, 12'h070, 32'hFF, 8'h0F);
    rd_chk("R5 clear ignored", 12'h040, 32'h0F);

    // R9 enable plain and masked
    cyc(1'b1, 12'h050, 32'h3C, 8'h0F);
    rd_chk("R9 plain", 12'h050, 32'h3C);
    cyc(1'b1, 12'h850, 32'h0F0A, 8'h0F);
    rd_chk("R9 masked", 12'h050, 32'h3A);
    cmp("R9");

    // R10 trigger plain and masked
    cyc(1'b1, 12'h060, 32'h123456, 8'h0F);
    rd_chk("R10 plain", 12'h060, 32'h123456);
    cyc(1'b1, 12'h860, 32'hF0AA, 8'h0F);
    rd_chk("R10 masked", 12'h060, 32'h1234A6);
    cmp("R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule